// File: doc/BRIEF.md
# I2C Master SCL Phase Timer

This block times the low and high phases of the serial clock line for an I2C master, counting cycles of the peripheral clock. A 16-bit clock control word holds a 12-bit division factor, a bit that selects standard or fast mode, and a fast-mode bit that selects the low/high ratio. That word can be written only while the interface enable is low. Software therefore sets the bus timing first and then enables the interface.

While the interface is enabled and `run` is high, SCL alternates between a low phase and a high phase. Each phase is a whole multiple of the division factor. A one-cycle strobe marks every falling and every rising transition of SCL. When either input drops, SCL returns high at once and stays there.

Top module: `i2c_scl_clkgen`

## Requirements
- R1: After reset, `scl` is 1, both strobes are 0 and `cfg_q` reads 0x0000.
- R2: A write on `cfg_we` updates `cfg_q` at the next clock edge only when `en` is 0. When `en` is 1 the write is dropped and `cfg_q` keeps its value.
- R3: Bits 13:12 of the control word always read 0, whatever value is written to them.
- R4: While `en` and `run` are not both 1, `scl` is held at 1. Once both are 1, the first phase is a low phase.
- R5: Standard mode (bit 15 = 0; bit 14 has no effect here) gives a low phase of F cycles and a high phase of F cycles. F is the division factor in bits 11:0.
- R6: Fast mode (bit 15 = 1) with bit 14 = 0 gives a low phase of 2·F cycles and a high phase of F cycles.
- R7: Fast mode with bit 14 = 1 gives a low phase of 16·F cycles and a high phase of 9·F cycles.
- R8: A division factor of 0 behaves as a factor of 1.
- R9: `fall_stb` is 1 for exactly the cycle in which `scl` first reads 0 after reading 1. `rise_stb` is 1 for exactly the cycle in which `scl` first reads 1 after reading 0. The two strobes are never 1 together.
- R10: If `run` or `en` drops during a low phase, `scl` reads 1 in the following cycle and `rise_stb` fires in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable; locks the control word while high |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_q | output | 16 | Current control word |
| run | input | 1 | Request to toggle SCL |
| scl | output | 1 | SCL drive level |
| fall_stb | output | 1 | One-cycle pulse on an SCL high-to-low transition |
| rise_stb | output | 1 | One-cycle pulse on an SCL low-to-high transition |

## Verification
The hardest case to reach is `run` being dropped partway through a low phase, because that phase is then cut short rather than completed. To get there, the stimulus lets the scoreboard drain all the complete phases it expects, then deasserts `run` a few cycles into a fresh low phase. It then checks the immediate return to high and the rise strobe in that cycle. A second hard case is the zero division factor, where SCL changes level on every cycle. There, the strobe checks must hold on back-to-back transitions.

// File: rtl/i2c_scl_clkgen.sv
module i2c_scl_clkgen #(
  parameter int DIV_W = 12,
  parameter int CNT_W = DIV_W + 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_q,
  input  logic        run,
  output logic        scl,
  output logic        fall_stb,
  output logic        rise_stb
);

  localparam int          FAST_BIT = 15;
  localparam int          DUTY_BIT = 14;
  localparam logic [15:0] CFG_MASK = 16'hC000 | 16'((32'd1 << DIV_W) - 1);

  logic             scl_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] fac, low_len, high_len;
  logic             gen;

  assign gen = en & run;
  assign fac = (cfg_q[DIV_W-1:0] == '0) ? CNT_W'(1) : CNT_W'(cfg_q[DIV_W-1:0]);

  always_comb begin
    if (!cfg_q[FAST_BIT]) begin
      low_len  = fac;
      high_len = fac;
    end else if (!cfg_q[DUTY_BIT]) begin
      low_len  = fac << 1;
      high_len = fac;
    end else begin
      low_len  = fac << 4;
      high_len = (fac << 3) + fac;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      scl_q    <= 1'b1;
      cnt      <= '0;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end else begin
      if (cfg_we && !en) cfg_q <= cfg_wdata & CFG_MASK;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      if (!gen) begin
        scl_q    <= 1'b1;
        cnt      <= '0;
        rise_stb <= !scl_q;
      end else if (cnt == '0) begin
        scl_q <= !scl_q;
        if (scl_q) begin
          fall_stb <= 1'b1;
          cnt      <= low_len - 1'b1;
        end else begin
          rise_stb <= 1'b1;
          cnt      <= high_len - 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign scl = scl_q;

  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(cfg_q));
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[13:12] == 2'b00);
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |=> scl);
  p_fall_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!scl && $past(scl)));
  p_rise_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl && !$past(scl)));
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_stb && rise_stb));
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen && !scl) |=> (scl && rise_stb));

endmodule

// File: tb/i2c_scl_clkgen_bench.sv
module i2c_scl_clkgen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_q;
  logic        run = 1'b0;
  logic        scl, fall_stb, rise_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [17:0] expq[$];

  always #4 clk = ~clk;

  i2c_scl_clkgen u_i2c_scl_clkgen (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .run(run), .scl(scl), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: phase lengths against the scoreboard queue, strobes against scl edges
  initial begin
    logic prev = 1'b1;
    bit   tracking = 1'b0;
    int   len = 0;
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        if (fall_stb || rise_stb || (prev != scl)) begin
          check("R9 fall strobe", int'(fall_stb), int'(prev && !scl));
          check("R9 rise strobe", int'(rise_stb), int'(!prev && scl));
        end
        if (!(en && run)) begin
          tracking = 1'b0;
        end else if (scl != prev) begin
          if (tracking && expq.size() > 0) begin
            logic [17:0] e;
            e = expq.pop_front();
            check("R5-R8 phase level", int'(prev), int'(e[17]));
            check("R5-R8 phase length", len, int'(e[16:0]));
          end
          tracking = 1'b1;
          len = 1;
        end else begin
          len++;
        end
        prev = scl;
      end
    end
  end

  task automatic write_cfg(input logic [15:0] d);
    @(negedge clk);
    en = 1'b0; cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_phases(input logic [15:0] word, input int nph);
    int f, lo, hi;
    f = (word[11:0] == 0) ? 1 : int'(word[11:0]);
    if (!word[15])     begin lo = f;      hi = f;     end
    else if (!word[14]) begin lo = 2 * f;  hi = f;     end
    else               begin lo = 16 * f; hi = 9 * f; end
    write_cfg(word);
    for (int i = 0; i < nph; i++)
      expq.push_back({(i % 2 == 0) ? 1'b0 : 1'b1, 17'(((i % 2) == 0) ? lo : hi)});
    @(negedge clk);
    en = 1'b1; run = 1'b1;
    @(posedge clk); #2;
    check("R4 first phase low", int'(scl), 0);
    while (expq.size() > 0) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 idle high after stop", int'(scl), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 scl reset", int'(scl), 1);
    check("R1 fall reset", int'(fall_stb), 0);
    check("R1 rise reset", int'(rise_stb), 0);
    check("R1 cfg reset", int'(cfg_q), 0);
    rst_n = 1'b1;

    write_cfg(16'hFFFF);
    check("R3 reserved bits", int'(cfg_q), 16'hCFFF);
    write_cfg(16'h0003);
    check("R2 write while off", int'(cfg_q), 3);
    @(negedge clk);
    en = 1'b1; cfg_we = 1'b1; cfg_wdata = 16'h8123;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    check("R2 write while on ignored", int'(cfg_q), 3);
    en = 1'b0;

    @(negedge clk);
    en = 1'b0; run = 1'b1;
    repeat (5) @(negedge clk);
    check("R4 run without enable", int'(scl), 1);
    run = 1'b0; en = 1'b1;
    repeat (5) @(negedge clk);
    check("R4 enable without run", int'(scl), 1);

    run_phases(16'h0003, 6);   // R5
    run_phases(16'h4005, 4);   // R5 duty bit ignored in standard mode
    run_phases(16'h8002, 6);   // R6
    run_phases(16'hC001, 4);   // R7
    run_phases(16'h0000, 8);   // R8
    run_phases(16'hC000, 4);   // R8 with R7 ratio
    run_phases(16'h8000, 4);   // R8 with R6 ratio

    write_cfg(16'h0005);
    @(negedge clk);
    en = 1'b1; run = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 low before stop", int'(scl), 0);
    run = 1'b0;
    @(posedge clk); #2;
    check("R10 scl released", int'(scl), 1);
    check("R10 rise strobe", int'(rise_stb), 1);
    @(posedge clk); #2;
    check("R9 strobe one cycle", int'(rise_stb), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule